// File: doc/BRIEF.md
# External Reset Pulse Generator

This block turns a watchdog expiry event into a reset pulse on an external line. When the trip input is seen, the line goes to its active level for a programmed number of microsecond ticks and then returns to idle. The length of the pulse, the active polarity and the drive style all live in one 32-bit configuration word that is written through a simple write port.

The polarity and drive style are protected. They change only when the most significant byte of a write holds one of four key values. Every write, keyed or not, loads the pulse-length field from the low bits of the same word.

The pad is modelled by a data output and an output enable. Push-pull drive keeps the enable on at all times. Open-drain drive turns the enable on only while the line is held at its active level.

Top module: `extrst_pulse_gen`

## Requirements
- R1: The length field is `cfg_wdata[19:0]`. A stored value N holds the line active for exactly N+1 periods of `tick_1us`, measured from the trip to the tick that ends the pulse.
- R2: A write whose top byte `cfg_wdata[31:24]` is 0xA5 selects active-high polarity (active level 1, idle level 0).
- R3: A write whose top byte is 0x5A selects active-low polarity (active level 0, idle level 1).
- R4: A write whose top byte is 0xA8 selects push-pull drive.
- R5: A write whose top byte is 0x8A selects open-drain drive.
- R6: A keyed write also loads the length field from the same word.
- R7: A write whose top byte matches none of the four keys loads only the length field and leaves polarity and drive style unchanged.
- R8: A trip that arrives while a pulse is active restarts the length count from the stored value, so the pulse ends N+1 ticks after the last trip.
- R9: In open-drain drive, `rst_line_oe` is 1 only while `rst_line` is at its active level, and it is 0 while the line is idle.
- R10: In push-pull drive, `rst_line_oe` is 1 both during the pulse and while idle.
- R11: After reset the block uses active-low polarity, open-drain drive and a length of 0xFF. In that state `rst_line` is 1 and `rst_line_oe` is 0.
- R12: Both outputs are registered. A trip sampled on one clock edge shows on the pins after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1us | input | 1 | Single-cycle strobe, one per microsecond |
| wdt_trip | input | 1 | Single-cycle watchdog expiry strobe |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data: key byte on top, length in the low field |
| rst_line | output | 1 | Level driven toward the reset pad |
| rst_line_oe | output | 1 | Output enable for the reset pad |

## Verification
On every cycle, the assertions check four things. A write loads the length. A write without a key leaves both attributes alone. A trip arms the counter with the stored length. The final tick ends the pulse. They also check the enable rule for each drive style and the level driven during an open-drain pulse.

Other behaviour can only be shown by the bench scenarios:
- the total pulse length in ticks for several tick rates;
- the extension of a pulse when a second trip arrives;
- the idle levels that follow each keyed or unkeyed write;
- the reset defaults, including the full 256-tick default pulse.

// File: rtl/extrst_pkg.sv
package extrst_pkg;
  localparam int DATA_W  = 32;
  localparam int LEN_W   = 20;
  localparam int RST_LEN = 255;

  localparam logic [7:0] KEY_ACT_HIGH  = 8'hA5;
  localparam logic [7:0] KEY_ACT_LOW   = 8'h5A;
  localparam logic [7:0] KEY_PUSH_PULL = 8'hA8;
  localparam logic [7:0] KEY_OPEN_DRN  = 8'h8A;

  typedef struct packed {
    logic act_high;
    logic push_pull;
  } line_attr_t;
endpackage

// File: rtl/extrst_cfg.sv
module extrst_cfg
  import extrst_pkg::*;
#(
  parameter int DATA_W_P  = DATA_W,
  parameter int LEN_W_P   = LEN_W,
  parameter int RST_LEN_P = RST_LEN
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [DATA_W_P-1:0] wr_data,
  output line_attr_t          attr,
  output logic [LEN_W_P-1:0]  len
);
  localparam int KEY_LSB = DATA_W_P - 8;

  logic [7:0] key;
  logic       key_hit;

  assign key     = wr_data[DATA_W_P-1:KEY_LSB];
  assign key_hit = (key == KEY_ACT_HIGH) || (key == KEY_ACT_LOW) ||
                   (key == KEY_PUSH_PULL) || (key == KEY_OPEN_DRN);

  always_ff @(posedge clk) begin
    if (rst) begin
      attr <= '{act_high: 1'b0, push_pull: 1'b0};
      len  <= LEN_W_P'(RST_LEN_P);
    end else if (wr_en) begin
      len <= wr_data[LEN_W_P-1:0];
      case (key)
        KEY_ACT_HIGH:  attr.act_high  <= 1'b1;
        KEY_ACT_LOW:   attr.act_high  <= 1'b0;
        KEY_PUSH_PULL: attr.push_pull <= 1'b1;
        KEY_OPEN_DRN:  attr.push_pull <= 1'b0;
        default: ;
      endcase
    end
  end

  // R1 / R6: every write loads the length field
  assert_len_load_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (len == $past(wr_data[LEN_W_P-1:0])));

  // R7: an unkeyed write keeps both attributes
  assert_nokey_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !key_hit) |=> (attr == $past(attr)));
endmodule

// File: rtl/extrst_timer.sv
module extrst_timer #(
  parameter int LEN_W_P = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               trig,
  input  logic [LEN_W_P-1:0] len,
  output logic               active
);
  logic [LEN_W_P-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      remain <= '0;
    end else if (trig) begin
      active <= 1'b1;
      remain <= len;
    end else if (active && tick) begin
      if (remain == '0) active <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

  // R8: a trip (re)arms the counter with the stored length
  assert_trip_arm_R8: assert property (@(posedge clk) disable iff (rst)
    trig |=> (active && remain == $past(len)));

  // R1: the tick seen with zero left ends the pulse
  assert_last_tick_R1: assert property (@(posedge clk) disable iff (rst)
    (active && !trig && tick && remain == '0) |=> !active);
endmodule

// File: rtl/extrst_drive.sv
module extrst_drive
  import extrst_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       active,
  input  line_attr_t attr,
  output logic       pin_out,
  output logic       pin_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= 1'b1;
      pin_oe  <= 1'b0;
    end else begin
      pin_out <= active ? attr.act_high : ~attr.act_high;
      pin_oe  <= attr.push_pull | active;
    end
  end

  // R10: push-pull keeps the enable on
  assert_pp_oe_R10: assert property (@(posedge clk) disable iff (rst)
    attr.push_pull |=> pin_oe);

  // R9: open-drain drives only while active, at the active level
  assert_od_active_R9: assert property (@(posedge clk) disable iff (rst)
    (!attr.push_pull && active) |=> (pin_oe && pin_out == $past(attr.act_high)));

  assert_od_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!attr.push_pull && !active) |=> !pin_oe);
endmodule

// File: rtl/extrst_pulse_gen.sv
module extrst_pulse_gen
  import extrst_pkg::*;
#(
  parameter int DATA_W_P  = DATA_W,
  parameter int LEN_W_P   = LEN_W,
  parameter int RST_LEN_P = RST_LEN
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_1us,
  input  logic                wdt_trip,
  input  logic                cfg_we,
  input  logic [DATA_W_P-1:0] cfg_wdata,
  output logic                rst_line,
  output logic                rst_line_oe
);
  line_attr_t         attr;
  logic [LEN_W_P-1:0] len;
  logic               active;

  extrst_cfg #(
    .DATA_W_P (DATA_W_P),
    .LEN_W_P  (LEN_W_P),
    .RST_LEN_P(RST_LEN_P)
  ) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_we),
    .wr_data(cfg_wdata),
    .attr   (attr),
    .len    (len)
  );

  extrst_timer #(
    .LEN_W_P(LEN_W_P)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick_1us),
    .trig  (wdt_trip),
    .len   (len),
    .active(active)
  );

  extrst_drive u_drive (
    .clk    (clk),
    .rst    (rst),
    .active (active),
    .attr   (attr),
    .pin_out(rst_line),
    .pin_oe (rst_line_oe)
  );

  // R12: a trip shows on the pins after the next edge
  assert_latency_R12: assert property (@(posedge clk) disable iff (rst)
    $past(wdt_trip) |=> (rst_line == $past(attr.act_high, 1) || $past(rst)));
endmodule

// File: tb/tb_extrst_pulse_gen.sv
`timescale 1ns/1ps
module tb_extrst_pulse_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1us = 1'b0;
  logic        wdt_trip = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        rst_line;
  logic        rst_line_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  extrst_pulse_gen dut (
    .clk(clk), .rst(rst), .tick_1us(tick_1us), .wdt_trip(wdt_trip),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .rst_line(rst_line), .rst_line_oe(rst_line_oe)
  );

  localparam int NV = 6;
  localparam logic [31:0] V_WD [NV] = '{32'hA5000003, 32'hA8000004, 32'h5A000002,
                                        32'h12000006, 32'h8A000001, 32'h00000000};
  localparam int V_PER [NV] = '{1, 2, 1, 3, 4, 1};
  localparam bit V_POL [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam bit V_PP  [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam int V_LEN [NV] = '{4, 10, 3, 21, 8, 1};
  localparam string V_REQ [NV] = '{"R2 R6", "R4 R6", "R3 R6", "R7", "R5 R6", "R7"};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Trip, then tick every per cycles; optional second trip at offset retrig.
  task automatic run_pulse(input int per, input bit pol, input bit pp, input int retrig,
                           output int len, output bit oe_bad);
    bit seen;
    len = 0;
    oe_bad = 1'b0;
    seen = 1'b0;
    @(negedge clk);
    wdt_trip = 1'b1;
    tick_1us = 1'b0;
    for (int j = 1; j < 5000; j++) begin
      @(negedge clk);
      if (rst_line == pol) begin
        seen = 1'b1;
        len++;
        if (!rst_line_oe) oe_bad = 1'b1;
      end else begin
        if (rst_line_oe != pp) oe_bad = 1'b1;
        if (seen) break;
      end
      wdt_trip = (j == retrig);
      tick_1us = (j % per == 0);
    end
    wdt_trip = 1'b0;
    tick_1us = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int len;
    bit bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    check(rst_line == 1'b1, "R11 idle level", rst_line, 1);
    check(rst_line_oe == 1'b0, "R11 idle enable", rst_line_oe, 0);

    // R11 / R1: default length 0xFF gives 256 ticks
    run_pulse(1, 1'b0, 1'b0, 0, len, bad);
    check(len == 256, "R11 R1 default length", len, 256);
    check(!bad, "R9 default open-drain enable", bad, 0);

    // R12: output appears after the next edge
    @(negedge clk);
    wdt_trip = 1'b1;
    @(negedge clk);
    wdt_trip = 1'b0;
    check(rst_line == 1'b1, "R12 not before second edge", rst_line, 1);
    @(negedge clk);
    check(rst_line == 1'b0, "R12 after second edge", rst_line, 0);
    repeat (300) begin
      @(negedge clk);
      tick_1us = 1'b1;
    end
    tick_1us = 1'b0;

    for (int v = 0; v < NV; v++) begin
      do_write(V_WD[v]);
      check(rst_line == !V_POL[v], {V_REQ[v], " idle level"}, rst_line, !V_POL[v]);
      check(rst_line_oe == V_PP[v], {V_REQ[v], " R9 R10 idle enable"}, rst_line_oe, V_PP[v]);
      run_pulse(V_PER[v], V_POL[v], V_PP[v], 0, len, bad);
      check(len == V_LEN[v], {V_REQ[v], " R1 length"}, len, V_LEN[v]);
      check(!bad, {V_REQ[v], " R9 R10 enable in pulse"}, bad, 0);
    end

    // R8: retrigger during pulse, N=5, tick every cycle, second trip at offset 3
    do_write(32'hA5000005);
    run_pulse(1, 1'b1, 1'b0, 3, len, bad);
    check(len == 9, "R8 restart length", len, 9);
    check(!bad, "R8 R9 enable", bad, 0);

    // R8: single pulse with the same setting for contrast
    run_pulse(1, 1'b1, 1'b0, 0, len, bad);
    check(len == 6, "R8 R1 single length", len, 6);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule